// File: doc/BRIEF.md
# Dual-Source Horizontal Chunk Pager

This block sits between a CPU's 16-bit address bus and a physical RAM that is larger than the CPU can see. It divides the 64K space into eight 8K chunks. Each chunk is served either by the conventional home map or by one of two alternate 64K banks, called DOCK and EX. An eight-bit chunk-enable mask says which chunks come from an alternate bank. A single source bit picks which of the two alternate banks all of those chunks use. Because there is only one source bit, DOCK and EX can never be mapped at the same time.

The two control values are loaded by I/O writes to two ports, and the address decode compares all sixteen address bits. The source port can also be read back and returns the last byte written to it. For every CPU address the block forms a 17-bit physical address and a chip-select class. The classes are ROM, home RAM, DOCK and EX. A contention flag marks accesses to an odd bank in the home map's switchable top slot. The mapping is combinational from the registered control values.

Top module: `chunk_pager`

## Requirements
- R1: After reset the mask and the source byte are zero, so every chunk uses the home map and a read of port 0x00FF returns 0x00.
- R2: An I/O write with address exactly 0x00F4 loads the mask. The new mask governs the mapping from the cycle after the write strobe.
- R3: When mask bit n is set, n being the chunk number mem_addr[15:13], and the source bit is 0, the class is DOCK (code 1) and phys_addr is {1'b0, mem_addr}.
- R4: When mask bit n is set and the source bit is 1, the class is EX (code 2) and phys_addr is {1'b1, mem_addr}. The source bit is bit 7 of the last byte written to port 0x00FF, and one source bit applies to all enabled chunks.
- R5: I/O writes to any address other than exactly 0x00F4 or 0x00FF leave the mask and source byte unchanged, including aliases such as 0x01F4 or 0xFFFF. I/O reads never change them.
- R6: When the chunk's mask bit is clear, the home map applies by 16K slot mem_addr[15:14]. Slot 0 is class ROM (code 3) with phys_addr = mem_addr[13:0]. Slot 1 is home RAM (code 0) bank 5, slot 2 is bank 2, and slot 3 is bank page_bank. For the RAM slots phys_addr = {bank, mem_addr[13:0]}.
- R7: contended is 1 exactly when the class is home RAM, the slot is 3 and page_bank is odd. Alternate chunks are never contended.
- R8: With io_rd high and io_addr exactly 0x00FF, io_rdata is the full last byte written to 0x00FF. Otherwise io_rdata is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_wr | input | 1 | I/O write strobe |
| io_rd | input | 1 | I/O read strobe |
| io_addr | input | 16 | I/O port address |
| io_wdata | input | 8 | I/O write data |
| io_rdata | output | 8 | I/O read data |
| mem_addr | input | 16 | CPU memory address |
| page_bank | input | 3 | Bank selected for the home top slot |
| phys_addr | output | 17 | Physical RAM/ROM address |
| cs_class | output | 2 | 0 home RAM, 1 DOCK, 2 EX, 3 ROM |
| contended | output | 1 | Access to an odd bank in the home top slot |

## Verification
The assertions take for granted that io_addr, io_wdata and the strobes are stable around each rising edge. They also rely on reset being asserted at start-up before any strobe is honoured. The bench changes every input only on the falling edge and holds reset for several cycles before any traffic. Its I/O addresses are biased toward the two ports and their near aliases, so the full-decode rule is exercised and the stimulus never relies on timing within a cycle.

// File: rtl/chunk_pager_pkg.sv
package chunk_pager_pkg;
  localparam int CPU_AW   = 16;
  localparam int CHUNK_W  = 3;
  localparam int BANK_W   = 3;
  localparam int SLOT_OFF = CPU_AW - 2;
  localparam int PHYS_W   = CPU_AW + 1;

  typedef enum logic [1:0] {
    CS_HOME = 2'd0,
    CS_DOCK = 2'd1,
    CS_EX   = 2'd2,
    CS_ROM  = 2'd3
  } cs_class_e;

  // Bank that the home map places in a 16K slot.
  function automatic logic [BANK_W-1:0] home_bank(input logic [1:0] slot,
                                                  input logic [BANK_W-1:0] sel);
    case (slot)
      2'd0:    home_bank = '0;
      2'd1:    home_bank = BANK_W'(5);
      2'd2:    home_bank = BANK_W'(2);
      default: home_bank = sel;
    endcase
  endfunction

  function automatic cs_class_e home_class(input logic [1:0] slot);
    home_class = (slot == 2'd0) ? CS_ROM : CS_HOME;
  endfunction
endpackage

// File: rtl/pager_regs.sv
module pager_regs #(
  parameter int AW        = 16,
  parameter int DW        = 8,
  parameter int MASK_PORT = 16'h00F4,
  parameter int SRC_PORT  = 16'h00FF
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          io_wr,
  input  logic          io_rd,
  input  logic [AW-1:0] io_addr,
  input  logic [DW-1:0] io_wdata,
  output logic [DW-1:0] io_rdata,
  output logic [DW-1:0] mask_q,
  output logic [DW-1:0] src_byte_q,
  output logic          hit_mask_wr,
  output logic          hit_src_wr
);
  logic sel_mask, sel_src;

  assign sel_mask    = (io_addr == AW'(MASK_PORT));
  assign sel_src     = (io_addr == AW'(SRC_PORT));
  assign hit_mask_wr = io_wr && sel_mask;
  assign hit_src_wr  = io_wr && sel_src;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q     <= '0;
      src_byte_q <= '0;
    end else begin
      if (hit_mask_wr) mask_q <= io_wdata;
      if (hit_src_wr)  src_byte_q <= io_wdata;
    end
  end

  assign io_rdata = (io_rd && sel_src) ? src_byte_q : '0;
endmodule

// File: rtl/pager_map.sv
module pager_map
  import chunk_pager_pkg::*;
#(
  parameter int NCHUNK = 8
) (
  input  logic [CPU_AW-1:0] mem_addr,
  input  logic [NCHUNK-1:0] mask,
  input  logic              src_ex,
  input  logic [BANK_W-1:0] page_bank,
  output logic [PHYS_W-1:0] phys_addr,
  output cs_class_e         cs_class,
  output logic              alt_hit
);
  logic [CHUNK_W-1:0] chunk;
  logic [1:0]         slot;
  logic [NCHUNK-1:0]  chunk_on;

  assign chunk = mem_addr[CPU_AW-1 -: CHUNK_W];
  assign slot  = mem_addr[CPU_AW-1 -: 2];

  for (genvar i = 0; i < NCHUNK; i++) begin : g_chunk
    assign chunk_on[i] = mask[i] && (chunk == CHUNK_W'(i));
  end

  assign alt_hit = |chunk_on;

  always_comb begin
    if (alt_hit) begin
      phys_addr = {src_ex, mem_addr};
      cs_class  = src_ex ? CS_EX : CS_DOCK;
    end else begin
      phys_addr = {home_bank(slot, page_bank), mem_addr[SLOT_OFF-1:0]};
      cs_class  = home_class(slot);
    end
  end
endmodule

// File: rtl/pager_contend.sv
module pager_contend
  import chunk_pager_pkg::*;
(
  input  logic [1:0]        slot,
  input  logic [BANK_W-1:0] page_bank,
  input  logic              alt_hit,
  output logic              contended
);
  assign contended = !alt_hit && (slot == 2'd3) && page_bank[0];
endmodule

// File: rtl/chunk_pager.sv
module chunk_pager
  import chunk_pager_pkg::*;
#(
  parameter int MASK_PORT = 16'h00F4,
  parameter int SRC_PORT  = 16'h00FF,
  parameter int SRC_BIT   = 7,
  parameter int DW        = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              io_wr,
  input  logic              io_rd,
  input  logic [15:0]       io_addr,
  input  logic [7:0]        io_wdata,
  output logic [7:0]        io_rdata,
  input  logic [15:0]       mem_addr,
  input  logic [2:0]        page_bank,
  output logic [16:0]       phys_addr,
  output logic [1:0]        cs_class,
  output logic              contended
);
  localparam int NCHUNK = 1 << CHUNK_W;

  logic [DW-1:0] mask_q, src_byte_q;
  logic          hit_mask_wr, hit_src_wr, alt_hit;
  cs_class_e     cls;

  pager_regs #(
    .AW(CPU_AW), .DW(DW), .MASK_PORT(MASK_PORT), .SRC_PORT(SRC_PORT)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .io_wr(io_wr), .io_rd(io_rd),
    .io_addr(io_addr), .io_wdata(io_wdata), .io_rdata(io_rdata),
    .mask_q(mask_q), .src_byte_q(src_byte_q),
    .hit_mask_wr(hit_mask_wr), .hit_src_wr(hit_src_wr)
  );

  pager_map #(.NCHUNK(NCHUNK)) u_map (
    .mem_addr(mem_addr), .mask(mask_q[NCHUNK-1:0]),
    .src_ex(src_byte_q[SRC_BIT]), .page_bank(page_bank),
    .phys_addr(phys_addr), .cs_class(cls), .alt_hit(alt_hit)
  );

  pager_contend u_cont (
    .slot(mem_addr[CPU_AW-1 -: 2]), .page_bank(page_bank),
    .alt_hit(alt_hit), .contended(contended)
  );

  assign cs_class = cls;
endmodule

// File: rtl/chunk_pager_chk.sv
module chunk_pager_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        io_wr,
  input logic        io_rd,
  input logic [15:0] io_addr,
  input logic [7:0]  io_wdata,
  input logic [7:0]  io_rdata,
  input logic [15:0] mem_addr,
  input logic [1:0]  cs_class,
  input logic        contended,
  input logic [7:0]  mask_q,
  input logic [7:0]  src_byte_q,
  input logic        hit_mask_wr,
  input logic        hit_src_wr
);
  // R2: mask port write lands on the next cycle
  p_mask_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && io_addr == 16'h00F4) |=> (mask_q == $past(io_wdata)));

  // R5: alias or non-port writes leave state untouched
  p_alias_ignored_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(io_wr && (io_addr == 16'h00F4 || io_addr == 16'h00FF))
      |=> ($stable(mask_q) && $stable(src_byte_q)));

  // R5: at most one port decoder fires
  p_one_decode_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({hit_mask_wr, hit_src_wr}));

  // R3: DOCK only with the source bit clear and the chunk enabled
  p_dock_src_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_class == 2'd1) |-> (!src_byte_q[7] && mask_q[mem_addr[15:13]]));

  // R4: EX only with the source bit set and the chunk enabled
  p_ex_src_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_class == 2'd2) |-> (src_byte_q[7] && mask_q[mem_addr[15:13]]));

  // R7: contention only in the home top slot
  p_contend_slot_r7: assert property (@(posedge clk) disable iff (!rst_n)
    contended |-> (cs_class == 2'd0 && mem_addr[15:14] == 2'b11));

  // R8: reads elsewhere return zero
  p_rdata_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(io_rd && io_addr == 16'h00FF) |-> (io_rdata == 8'h00));

  // R8: read-back follows a source write
  p_rdata_back_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && io_addr == 16'h00FF) |=> (src_byte_q == $past(io_wdata)));
endmodule

bind chunk_pager chunk_pager_chk u_chk (
  .clk(clk), .rst_n(rst_n), .io_wr(io_wr), .io_rd(io_rd),
  .io_addr(io_addr), .io_wdata(io_wdata), .io_rdata(io_rdata),
  .mem_addr(mem_addr), .cs_class(cs_class), .contended(contended),
  .mask_q(mask_q), .src_byte_q(src_byte_q),
  .hit_mask_wr(hit_mask_wr), .hit_src_wr(hit_src_wr)
);

// File: tb/chunk_pager_bench.sv
module chunk_pager_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        io_wr = 1'b0, io_rd = 1'b0;
  logic [15:0] io_addr = '0, mem_addr = '0;
  logic [7:0]  io_wdata = '0;
  logic [2:0]  page_bank = '0;
  logic [7:0]  io_rdata;
  logic [16:0] phys_addr;
  logic [1:0]  cs_class;
  logic        contended;

  int compared = 0, mismatched = 0;
  int m_mask = 0, m_src = 0;  // reference model state
  bit done = 0;

  always #2 clk = ~clk;  // 250 MHz

  chunk_pager u_chunk_pager (
    .clk(clk), .rst_n(rst_n), .io_wr(io_wr), .io_rd(io_rd),
    .io_addr(io_addr), .io_wdata(io_wdata), .io_rdata(io_rdata),
    .mem_addr(mem_addr), .page_bank(page_bank), .phys_addr(phys_addr),
    .cs_class(cs_class), .contended(contended)
  );

  task automatic check(input string req, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Compare all outputs against the model for the current inputs.
  task automatic compare_now();
    int chunk, slot, off, e_phys, e_cls, e_cont, e_rd;
    string rq;
    chunk = mem_addr / 8192;
    slot  = mem_addr / 16384;
    off   = mem_addr % 16384;
    if ((m_mask >> chunk) % 2 == 1) begin
      e_cls = (m_src >= 128) ? 2 : 1;
      e_phys = ((m_src >= 128) ? 65536 : 0) + mem_addr;
      rq = (e_cls == 2) ? "R4" : "R3";
    end else begin
      rq = "R6";
      case (slot)
        0: begin e_cls = 3; e_phys = off; end
        1: begin e_cls = 0; e_phys = 5 * 16384 + off; end
        2: begin e_cls = 0; e_phys = 2 * 16384 + off; end
        default: begin e_cls = 0; e_phys = page_bank * 16384 + off; end
      endcase
    end
    e_cont = (e_cls == 0 && slot == 3 && page_bank % 2 == 1) ? 1 : 0;
    e_rd = (io_rd && io_addr == 16'h00FF) ? m_src : 0;
    check({rq, " class"}, cs_class, e_cls);
    check({rq, " phys"}, phys_addr, e_phys);
    check("R7 contended", contended, e_cont);
    check("R8 rdata", io_rdata, e_rd);
  endtask

  // One bus cycle: drive on falling edge, compare, update model at rising edge.
  task automatic cyc(input bit wr, input bit rd, input int ia, input int wd,
                     input int ma, input int pb);
    @(negedge clk);
    io_wr = wr; io_rd = rd; io_addr = 16'(ia); io_wdata = 8'(wd);
    mem_addr = 16'(ma); page_bank = 3'(pb);
    #1 compare_now();
    @(posedge clk);
    if (wr && ia == 16'h00F4) m_mask = wd;
    if (wr && ia == 16'h00FF) m_src = wd;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      mismatched++; compared++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin : stim
    int ports[6];
    ports = '{16'h00F4, 16'h00FF, 16'h01F4, 16'hFFFF, 16'h80FF, 16'h00F5};
    repeat (4) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    // R1: reset state, all chunks home, read-back zero
    for (int c = 0; c < 8; c++) cyc(0, 1, 16'h00FF, 0, c * 8192 + 123, 3);
    // R2: mask write then immediate effect next cycle; R3 DOCK
    cyc(1, 0, 16'h00F4, 8'hA5, 16'h0000, 0);
    for (int c = 0; c < 8; c++) cyc(0, 0, 0, 0, c * 8192 + 16'h1ABC, 1);
    // R4: switch to EX, all enabled chunks follow
    cyc(1, 0, 16'h00FF, 8'h80, 16'hE000, 1);
    for (int c = 0; c < 8; c++) cyc(0, 1, 16'h00FF, 0, c * 8192 + 16'h0F0F, 7);
    // R5: alias writes must not change mask or source
    cyc(1, 0, 16'h01F4, 8'h00, 0, 0);
    cyc(1, 0, 16'hFFFF, 8'h00, 0, 0);
    cyc(1, 0, 16'h80FF, 8'h00, 0, 0);
    cyc(0, 1, 16'h00F4, 8'h00, 16'h0000, 0);
    cyc(0, 1, 16'h00FF, 0, 16'hE123, 0);
    // R7: top slot with odd and even banks, mask cleared
    cyc(1, 0, 16'h00F4, 8'h00, 0, 0);
    for (int b = 0; b < 8; b++) cyc(0, 0, 0, 0, 16'hC000 + b, b);
    // mixed traffic, compared every cycle
    for (int i = 0; i < 3000; i++) begin
      int r;
      r = $urandom % 8;
      cyc(r < 3, r == 3 || r == 4,
          (r < 6) ? ports[$urandom % 6] : ($urandom % 65536),
          $urandom % 256, $urandom % 65536, $urandom % 8);
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule